// File: doc/BRIEF.md
# Pseudo-Random Link Word Error Checker

This block watches a 36-lane parallel word that arrives on every clock and compares each lane with the value it should carry. Lanes 0 to 31 are checked against 32 local 16-bit pseudo-random generators. Each generator is seeded separately and starts stepping when a run begins. Lane 34 is a frame marker that must pulse once every eight cycles. Lane 32 carries a bunch-crossing number, sent one bit per cycle with the least significant bit first. Lane 33 must stay low. Lane 35 is a parity bit over all the other lanes.

Every lane has its own 8-bit error counter, which stops at its maximum value. A 48-bit counter records how many words were checked. A run begins on a start pulse and ends on a halt pulse; while no run is active, every counter holds its value. A clear pulse zeroes all counters without ending the run. A one-cycle error pulse lets an outer controller stop a run on the first bad word.

The checker finds the frame phase by itself: it locks on the first marker it sees after start. It learns the bunch-crossing number by capturing the first full frame group that follows the lock. From then on it predicts every later group itself.

Top module: `lane_pattern_checker`

## Requirements
- R1: Lane i (0..31) is expected to equal bit 0 of generator i. A start pulse loads generator i from seeds[16*i +: 16], so the first checked word expects bit 0 of the seed. After each checked word the generator steps to {~(s[0]^s[1]^s[3]^s[12]), s[15:1]}.
- R2: After start, the first word with lane 34 high sets frame phase 0. From then on, lane 34 must be 1 exactly at phase 0 of every 8-cycle group. A missing or extra marker counts one error on lane 34 for each word.
- R3: Lane 32 carries bit p of the group's bunch-crossing value at phase p. The first group after lock is captured and not checked. Each later group expects the previous value plus one, and 159 is followed by 1. Each wrong bit counts one error on lane 32.
- R4: Lane 33 must be 0 in every checked word; a 1 counts one error on lane 33.
- R5: Lane 35 must equal the XOR of lanes 0..34; a mismatch counts one error on lane 35.
- R6: The error count of lane i is err_cnt[8*i +: 8]. It rises by one for each checked word with a mismatch on that lane, and it holds at 255.
- R7: word_cnt rises by one for every checked word.
- R8: Words are checked from the cycle after a start pulse up to and including the cycle in which halt is high. When start and halt are both high, halt wins. While no run is active, no counter changes.
- R9: A clear pulse zeroes every error counter and word_cnt at the next edge, taking priority over any increment. A run in progress continues.
- R10: err_pulse is high in the cycle after a checked word that had a mismatch on any lane, and low otherwise.
- R11: After reset, all counters are 0, err_pulse is 0 and no run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: load seeds, begin run, relock frame phase |
| halt | input | 1 | Pulse: end the run, freeze all counters |
| clear | input | 1 | Pulse: zero error and word counters |
| rx_word | input | 36 | Received link word |
| seeds | input | 512 | Generator seeds, 16 bits per data lane |
| err_cnt | output | 288 | Per-lane saturating error counts, 8 bits per lane |
| word_cnt | output | 48 | Number of checked words |
| err_pulse | output | 1 | Mismatch seen in the previous checked word |

## Verification
Every counter, and err_pulse, reflects the word presented in a cycle one edge later. The bench therefore drives a word, waits for the next rising edge plus a small offset, and only then samples. A start pulse opens checking one cycle later, and the checks count words from that edge. The frame marker locks within eight cycles of start and the bunch-crossing lane is compared only after a further eight. For this reason error injections in the bench begin only after a warm-up of twenty cycles, and the counts are compared after two clean cycles.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int LFSR_W = 16;

    // one right shift of a data-lane generator; inverted feedback enters the MSB
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {~(s[0] ^ s[1] ^ s[3] ^ s[12]), s[LFSR_W-1:1]};
    endfunction

endpackage

// File: rtl/lpc_lfsr_bank.sv
module lpc_lfsr_bank
    import lpc_pkg::*;
#(
    parameter int NUM_LFSR = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       step,
    input  logic [NUM_LFSR*LFSR_W-1:0] seeds,
    output logic [NUM_LFSR-1:0]        exp_bits
);

    for (genvar g = 0; g < NUM_LFSR; g++) begin : g_gen
        logic [LFSR_W-1:0] state_d, state_q;

        always_comb begin
            state_d = state_q;
            if (load) begin
                state_d = seeds[g*LFSR_W +: LFSR_W];
            end else if (step) begin
                state_d = lfsr_step(state_q);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= '0;
            end else begin
                state_q <= state_d;
            end
        end

        assign exp_bits[g] = state_q[0];
    end

endmodule

// File: rtl/lpc_aux_check.sv
module lpc_aux_check #(
    parameter int FRAME_LEN = 8,
    parameter int BX_MAX    = 159,
    parameter int BX_MIN    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       active,
    input  logic       data_xor,
    input  logic       bx_bit,
    input  logic       zero_bit,
    input  logic       mark_bit,
    input  logic       par_bit,
    output logic [3:0] miss      // [0] counter lane, [1] zero lane, [2] marker lane, [3] parity lane
);

    localparam int PH_W = $clog2(FRAME_LEN);
    localparam int BX_W = FRAME_LEN;

    typedef struct packed {
        logic            locked;
        logic            acq;
        logic [PH_W-1:0] phase;
        logic [BX_W-1:0] shreg;
        logic [BX_W-1:0] bx_exp;
    } aux_t;

    aux_t st_d, st_q;

    function automatic logic [BX_W-1:0] bx_next(input logic [BX_W-1:0] v);
        return (v >= BX_W'(BX_MAX)) ? BX_W'(BX_MIN) : v + 1'b1;
    endfunction

    logic [BX_W-1:0] grp;
    logic            last;
    logic [PH_W-1:0] nxt_phase;

    always_comb begin
        st_d           = st_q;
        grp            = st_q.shreg;
        grp[st_q.phase] = bx_bit;
        last           = (st_q.phase == PH_W'(FRAME_LEN - 1));
        nxt_phase      = last ? '0 : st_q.phase + 1'b1;

        if (start) begin
            st_d.locked = 1'b0;
            st_d.acq    = 1'b0;
            st_d.phase  = '0;
        end else if (active) begin
            if (!st_q.locked) begin
                if (mark_bit) begin
                    st_d.locked = 1'b1;
                    st_d.acq    = 1'b1;
                    st_d.phase  = PH_W'(1);
                    st_d.shreg  = grp;
                end
            end else begin
                st_d.phase = nxt_phase;
                if (st_q.acq) begin
                    st_d.shreg = grp;
                    if (last) begin
                        st_d.acq    = 1'b0;
                        st_d.bx_exp = bx_next(grp);
                    end
                end else if (last) begin
                    st_d.bx_exp = bx_next(st_q.bx_exp);
                end
            end
        end

        miss[0] = st_q.locked && !st_q.acq && (bx_bit != st_q.bx_exp[st_q.phase]);
        miss[1] = zero_bit;
        miss[2] = st_q.locked && (mark_bit != (st_q.phase == '0));
        miss[3] = par_bit != (data_xor ^ bx_bit ^ zero_bit ^ mark_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lpc_err_counters.sv
module lpc_err_counters #(
    parameter int NUM_LANES = 36,
    parameter int ERR_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       active,
    input  logic [NUM_LANES-1:0]       miss,
    output logic [NUM_LANES*ERR_W-1:0] cnt
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [ERR_W-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (clear) begin
                cnt_d = '0;
            end else if (active && miss[g] && (cnt_q != {ERR_W{1'b1}})) begin
                cnt_d = cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign cnt[g*ERR_W +: ERR_W] = cnt_q;
    end

endmodule

// File: rtl/lane_pattern_checker.sv
module lane_pattern_checker
    import lpc_pkg::*;
#(
    parameter int NUM_LFSR  = 32,
    parameter int ERR_W     = 8,
    parameter int WCNT_W    = 48,
    parameter int FRAME_LEN = 8,
    parameter int BX_MAX    = 159,
    parameter int BX_MIN    = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic                                halt,
    input  logic                                clear,
    input  logic [NUM_LFSR+3:0]                 rx_word,
    input  logic [NUM_LFSR*LFSR_W-1:0]          seeds,
    output logic [(NUM_LFSR+4)*ERR_W-1:0]       err_cnt,
    output logic [WCNT_W-1:0]                   word_cnt,
    output logic                                err_pulse
);

    localparam int NUM_LANES = NUM_LFSR + 4;
    localparam int BX_LANE   = NUM_LFSR;
    localparam int ZERO_LANE = NUM_LFSR + 1;
    localparam int MARK_LANE = NUM_LFSR + 2;
    localparam int PAR_LANE  = NUM_LFSR + 3;

    typedef struct packed {
        logic              active;
        logic [WCNT_W-1:0] word_cnt;
        logic              err_pulse;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_LFSR-1:0]  exp_bits;
    logic [3:0]           aux_miss;
    logic [NUM_LANES-1:0] miss_all;
    logic                 run_active;

    lpc_lfsr_bank #(
        .NUM_LFSR (NUM_LFSR)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .step     (st_q.active),
        .seeds    (seeds),
        .exp_bits (exp_bits)
    );

    lpc_aux_check #(
        .FRAME_LEN (FRAME_LEN),
        .BX_MAX    (BX_MAX),
        .BX_MIN    (BX_MIN)
    ) u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .active   (st_q.active),
        .data_xor (^rx_word[NUM_LFSR-1:0]),
        .bx_bit   (rx_word[BX_LANE]),
        .zero_bit (rx_word[ZERO_LANE]),
        .mark_bit (rx_word[MARK_LANE]),
        .par_bit  (rx_word[PAR_LANE]),
        .miss     (aux_miss)
    );

    assign miss_all = {aux_miss, rx_word[NUM_LFSR-1:0] ^ exp_bits};

    lpc_err_counters #(
        .NUM_LANES (NUM_LANES),
        .ERR_W     (ERR_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .active (st_q.active),
        .miss   (miss_all),
        .cnt    (err_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (halt) begin
            st_d.active = 1'b0;
        end else if (start) begin
            st_d.active = 1'b1;
        end
        if (clear) begin
            st_d.word_cnt = '0;
        end else if (st_q.active) begin
            st_d.word_cnt = st_q.word_cnt + 1'b1;
        end
        st_d.err_pulse = st_q.active && (|miss_all);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_cnt   = st_q.word_cnt;
    assign err_pulse  = st_q.err_pulse;
    assign run_active = st_q.active;

endmodule

// File: rtl/lane_pattern_checker_chk.sv
module lane_pattern_checker_chk #(
    parameter int NUM_LANES = 36,
    parameter int ERR_W     = 8,
    parameter int WCNT_W    = 48
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clear,
    input logic                       active,
    input logic [NUM_LANES*ERR_W-1:0] err_cnt,
    input logic [WCNT_W-1:0]          word_cnt,
    input logic                       err_pulse
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // R6
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (err_cnt[g*ERR_W +: ERR_W] == {ERR_W{1'b1}} && !clear)
            |=> (err_cnt[g*ERR_W +: ERR_W] == {ERR_W{1'b1}}));

        // R6
        no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> (err_cnt[g*ERR_W +: ERR_W] >= $past(err_cnt[g*ERR_W +: ERR_W])));
    end

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word_cnt == '0 && err_cnt == '0));

    // R8
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clear) |=> ($stable(word_cnt) && $stable(err_cnt)));

    // R7
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clear) |=> (word_cnt == $past(word_cnt) + 1'b1));

    // R10
    pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !err_pulse);

endmodule

bind lane_pattern_checker lane_pattern_checker_chk #(
    .NUM_LANES (NUM_LANES),
    .ERR_W     (ERR_W),
    .WCNT_W    (WCNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .active    (run_active),
    .err_cnt   (err_cnt),
    .word_cnt  (word_cnt),
    .err_pulse (err_pulse)
);

// File: tb/lane_pattern_checker_test.sv
module lane_pattern_checker_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int NL = 36;

    // table: {lane[15:8], consecutive errored words[7:0]}
    localparam logic [15:0] VEC [10] = '{
        {8'd0, 8'd3}, {8'd31, 8'd1}, {8'd17, 8'd5}, {8'd32, 8'd2}, {8'd33, 8'd4},
        {8'd34, 8'd1}, {8'd35, 8'd2}, {8'd34, 8'd3}, {8'd32, 8'd1}, {8'd5, 8'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic halt = 1'b0;
    logic clear = 1'b0;
    logic [NL-1:0] rx_word = '0;
    logic [NP*16-1:0] seeds;
    logic [NL*8-1:0] err_cnt;
    logic [47:0] word_cnt;
    logic err_pulse;

    lane_pattern_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .clear(clear),
        .rx_word(rx_word), .seeds(seeds), .err_cnt(err_cnt),
        .word_cnt(word_cnt), .err_pulse(err_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] tx_lfsr [NP];
    int tx_phase = 3;
    logic [7:0] tx_bx = 8'd157;
    int inj_lane = -1;
    int exp_err [NL];
    longint exp_words = 0;
    bit exp_active = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    function automatic logic [NL-1:0] build_word();
        logic [NL-1:0] w;
        for (int i = 0; i < NP; i++) w[i] = tx_lfsr[i][0];
        w[32] = tx_bx[tx_phase];
        w[33] = 1'b0;
        w[34] = (tx_phase == 0);
        w[35] = ^w[34:0];
        if (inj_lane >= 0) begin
            w[inj_lane] = ~w[inj_lane];
            if (inj_lane != 35) w[35] = ~w[35];
        end
        return w;
    endfunction

    task automatic tick();
        rx_word = build_word();
        @(posedge clk);
        #1;
        if (clear) begin
            exp_words = 0;
            for (int l = 0; l < NL; l++) exp_err[l] = 0;
        end else if (exp_active) begin
            exp_words++;
            if (inj_lane >= 0 && exp_err[inj_lane] < 255) exp_err[inj_lane]++;
        end
        if (halt) exp_active = 0;
        else if (start) exp_active = 1;
        if (start) begin
            for (int i = 0; i < NP; i++) tx_lfsr[i] = seeds[i*16 +: 16];
        end else begin
            for (int i = 0; i < NP; i++)
                tx_lfsr[i] = {~(tx_lfsr[i][0] ^ tx_lfsr[i][1] ^ tx_lfsr[i][3] ^ tx_lfsr[i][12]),
                              tx_lfsr[i][15:1]};
        end
        if (tx_phase == 7) tx_bx = (tx_bx >= 8'd159) ? 8'd1 : tx_bx + 8'd1;
        tx_phase = (tx_phase + 1) % 8;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int l = 0; l < NL; l++) check(req, longint'(err_cnt[l*8 +: 8]), longint'(exp_err[l]));
        check(req, longint'(word_cnt), exp_words);
    endtask

    task automatic run_clean(input int n);
        inj_lane = -1;
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        for (int i = 0; i < NP; i++) begin
            seeds[i*16 +: 16] = 16'hACE1 + 16'(i) * 16'h3D25;
            tx_lfsr[i] = '0;
        end
        for (int l = 0; l < NL; l++) exp_err[l] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        check("R11 word_cnt", longint'(word_cnt), 0);
        check("R11 err_pulse", longint'(err_pulse), 0);
        check_all("R11 counters");

        // R8 errors before any start are ignored
        inj_lane = 33;
        for (int k = 0; k < 3; k++) tick();
        check_all("R8 idle before start");

        // start, then clean warm-up: R1 R2 R3 R4 R5 clean stream gives no error
        start = 1'b1; run_clean(1); start = 1'b0;
        run_clean(20);
        check_all("R1 R2 R3 R5 clean stream");
        check("R7 word count", longint'(word_cnt), 20);

        // table walk: one lane corrupted per entry
        foreach (VEC[e]) begin
            inj_lane = int'(VEC[e][15:8]);
            for (int k = 0; k < int'(VEC[e][7:0]); k++) begin
                tick();
                if (k == 0) check("R10 pulse after bad word", longint'(err_pulse), 1);
            end
            run_clean(1);
            check("R10 pulse after clean word", longint'(err_pulse), 0);
            run_clean(1);
            case (VEC[e][15:8])
                8'd32:   check_all("R3 counter lane");
                8'd33:   check_all("R4 zero lane");
                8'd34:   check_all("R2 marker lane");
                8'd35:   check_all("R5 parity lane");
                default: check_all("R1 data lane");
            endcase
        end

        // R6 saturation
        inj_lane = 7;
        for (int k = 0; k < 260; k++) tick();
        run_clean(1);
        check("R6 saturate lane 7", longint'(err_cnt[7*8 +: 8]), 255);
        check_all("R6 saturation");

        // R9 clear zeroes counters, run continues
        clear = 1'b1; run_clean(1); clear = 1'b0;
        check_all("R9 after clear");
        run_clean(2);
        check("R9 run continues", longint'(word_cnt), 2);

        // R8 halt freezes
        halt = 1'b1; run_clean(1); halt = 1'b0;
        inj_lane = 33;
        for (int k = 0; k < 5; k++) tick();
        run_clean(1);
        check_all("R8 halted freeze");
        check("R8 no pulse when halted", longint'(err_pulse), 0);

        // R8 halt beats start
        start = 1'b1; halt = 1'b1; run_clean(1); start = 1'b0; halt = 1'b0;
        run_clean(3);
        check_all("R8 halt priority");

        // R1 restart reloads seeds
        start = 1'b1; run_clean(1); start = 1'b0;
        run_clean(20);
        inj_lane = 0;
        for (int k = 0; k < 2; k++) tick();
        run_clean(1);
        check_all("R1 restart reload");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule